// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressed Memory Port

This block is a synchronous storage array addressed in bytes, reached through a CPU-side port that has a latched address register and a data buffer register. An active-low select enables the port. A single direction line then picks a read or a write. Each access moves one, two or four bytes, starting at any byte address Z. The bytes sit at Z, Z+1 and onward.

A runtime mode input chooses how those bytes map onto a word. In big-endian mode the byte at Z is the most significant byte. In little-endian mode it is the least significant byte. The same mapping applies when a word is split into bytes on a write and when bytes are joined into a word on a read. The data buffer register always drives the read-data output. After a read it holds the assembled word. After a write it holds the word that was stored.

Top module: `endian_mem`

## Requirements
- R1: Storage is an array of DEPTH 8-bit bytes, each at its own address. A byte write changes only the addressed byte, and a byte read of that address returns it.
- R2: While `sel_ni` is 1, no storage byte changes and neither `rdata_o` nor `mar_o` changes, whatever `rw_i`, `size_i`, `addr_i` and `wdata_i` carry.
- R3: A write is `sel_ni`=0 with `rw_i`=0. At that rising edge the selected bytes are stored, and from then on `rdata_o` equals the `wdata_i` that was sampled.
- R4: A read is `sel_ni`=0 with `rw_i`=1. The assembled value appears on `rdata_o` after that rising edge (one cycle of latency), and `mar_o` takes `addr_i` at every selected edge.
- R5: `size_i` encodes 00 as one byte at Z, 01 as two bytes at Z and Z+1, and 10 as four bytes at Z..Z+3. The code 11 behaves exactly as 10.
- R6: With `big_end_i`=1, the byte at Z is the most significant byte of the value, and later addresses are less significant.
- R7: With `big_end_i`=0, the byte at Z is the least significant byte of the value, and later addresses are more significant.
- R8: Bytes 02, 04, 06, 08 at 0x200..0x203 read as 0x02040608 (word, big-endian), 0x08060402 (word, little-endian), 0x0204 (half, big-endian) and 0x0402 (half, little-endian).
- R9: On byte and halfword reads, the unused upper bits of `rdata_o` are zero.
- R10: Byte addresses past DEPTH-1 wrap modulo DEPTH.
- R11: Stored bytes keep their value until a later write covers them, including across a change of `big_end_i`. Reset clears `rdata_o` and `mar_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the address and data buffer registers |
| sel_ni | input | 1 | Active-low port select |
| rw_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| big_end_i | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| addr_i | input | AW | Byte address Z |
| wdata_i | input | 32 | Write value, right-aligned |
| rdata_o | output | 32 | Data buffer register |
| mar_o | output | AW | Latched address register |

## Verification
The bench stores a word in one byte order and reads it back in the other. A design that tied the mode to storage instead of assembly would return the stored value unchanged rather than byte-swapped. It writes a word that straddles the top of the array and checks the low bytes at address zero. An adder that saturated or dropped the carry wrongly would corrupt those bytes or a byte just below the top. Byte and half reads are made over non-zero neighbours, so a missing zero-fill shows as stray upper bytes. Deselected cycles carry live write data, which exposes a write enable that ignores the select.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;

  function automatic int unsigned lane_count(logic [1:0] sz);
    return sz[1] ? 4 : (sz[0] ? 2 : 1);
  endfunction
endpackage

// File: rtl/mem_ctrl_decode.sv
module mem_ctrl_decode
  import endian_mem_pkg::*;
(
  input  logic             sel_ni,
  input  logic             rw_i,
  input  logic [1:0]       size_i,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic [LANES-1:0] lane_used_o
);
  assign rd_en_o = !sel_ni && rw_i;
  assign wr_en_o = !sel_ni && !rw_i;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      lane_used_o[k] = (k < int'(lane_count(size_i)));
  end
endmodule

// File: rtl/mem_lane_map.sv
module mem_lane_map
  import endian_mem_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                      big_end_i,
  input  logic [1:0]                size_i,
  input  logic [AW-1:0]             addr_i,
  output logic [LANES-1:0][AW-1:0]  lane_addr_o
);
  // lane k carries significance k (lane 0 = LSB)
  always_comb begin
    int n;
    n = int'(lane_count(size_i));
    for (int k = 0; k < LANES; k++) begin
      if (big_end_i) lane_addr_o[k] = addr_i + AW'(n - 1 - k);
      else           lane_addr_o[k] = addr_i + AW'(k);
    end
  end
endmodule

// File: rtl/mem_byte_array.sv
module mem_byte_array
  import endian_mem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [LANES-1:0]          lane_used_i,
  input  logic [LANES-1:0][AW-1:0]  lane_addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [LANES-1:0][7:0]     rbyte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < LANES; k++)
        if (lane_used_i[k]) mem_q[lane_addr_i[k]] <= wdata_i[8*k +: 8];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rbyte_o[k] = mem_q[lane_addr_i[k]];
  end
endmodule

// File: rtl/endian_mem.sv
module endian_mem
  import endian_mem_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          rw_i,
  input  logic [1:0]    size_i,
  input  logic          big_end_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] mar_o
);
  logic                     rd_en, wr_en;
  logic [LANES-1:0]         lane_used;
  logic [LANES-1:0][AW-1:0] lane_addr;
  logic [LANES-1:0][7:0]    rbyte;
  logic [DW-1:0]            rd_word;
  logic [AW-1:0]            mar_q;
  logic [DW-1:0]            mbr_q;

  mem_ctrl_decode u_dec (
    .sel_ni      (sel_ni),
    .rw_i        (rw_i),
    .size_i      (size_i),
    .rd_en_o     (rd_en),
    .wr_en_o     (wr_en),
    .lane_used_o (lane_used)
  );

  mem_lane_map #(.AW(AW)) u_map (
    .big_end_i   (big_end_i),
    .size_i      (size_i),
    .addr_i      (addr_i),
    .lane_addr_o (lane_addr)
  );

  mem_byte_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk_i       (clk_i),
    .we_i        (wr_en),
    .lane_used_i (lane_used),
    .lane_addr_i (lane_addr),
    .wdata_i     (wdata_i),
    .rbyte_o     (rbyte)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++)
      rd_word[8*k +: 8] = lane_used[k] ? rbyte[k] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
      mbr_q <= '0;
    end else if (!sel_ni) begin
      mar_q <= addr_i;
      mbr_q <= rd_en ? rd_word : wdata_i;
    end
  end

  assign rdata_o = mbr_q;
  assign mar_o   = mar_q;
endmodule

// File: rtl/endian_mem_chk.sv
module endian_mem_chk #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_ni,
  input logic          rw_i,
  input logic [1:0]    size_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic [AW-1:0] mar_o
);
  AST_DESEL_HOLD_MBR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> $stable(rdata_o)); // R2
  AST_DESEL_HOLD_MAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> $stable(mar_o)); // R2
  AST_WRITE_LOADS_MBR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !rw_i) |=> rdata_o == $past(wdata_i)); // R3
  AST_SEL_LOADS_MAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ni |=> mar_o == $past(addr_i)); // R4
  AST_BYTE_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && rw_i && size_i == 2'b00) |=> rdata_o[31:8] == 24'h0); // R9
  AST_HALF_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && rw_i && size_i == 2'b01) |=> rdata_o[31:16] == 16'h0); // R9
endmodule

bind endian_mem endian_mem_chk #(.AW(AW)) u_chk (.*);

// File: tb/endian_mem_tb.sv
`timescale 1ns/1ps
module endian_mem_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          sel_ni = 1;
  logic          rw_i = 1;
  logic [1:0]    size_i = 0;
  logic          big_end_i = 0;
  logic [AW-1:0] addr_i = 0;
  logic [31:0]   wdata_i = 0;
  logic [31:0]   rdata_o;
  logic [AW-1:0] mar_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  endian_mem #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, return at next negedge
  task automatic acc(bit sel_n, bit rd, logic [1:0] sz, bit be,
                     logic [AW-1:0] a, logic [31:0] wd);
    @(negedge clk_i);
    sel_ni = sel_n; rw_i = rd; size_i = sz; big_end_i = be;
    addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    sel_ni = 1;
  endtask

  task automatic wr(logic [1:0] sz, bit be, logic [AW-1:0] a, logic [31:0] wd);
    acc(0, 0, sz, be, a, wd);
  endtask

  task automatic rd(logic [1:0] sz, bit be, logic [AW-1:0] a);
    acc(0, 1, sz, be, a, 32'h0);
  endtask

  task automatic t_reset();
    chk("R11 reset rdata", rdata_o, 32'h0);
    chk("R11 reset mar", 32'(mar_o), 32'h0);
  endtask

  task automatic t_byte_rw();
    wr(2'b00, 0, 10'h010, 32'hFFFF_FF5A);
    chk("R3 write loads buffer", rdata_o, 32'hFFFF_FF5A);
    wr(2'b00, 0, 10'h011, 32'h0000_0077);
    rd(2'b00, 0, 10'h010);
    chk("R1 byte read", rdata_o, 32'h0000_005A);
    chk("R4 mar follows", 32'(mar_o), 32'h010);
    rd(2'b00, 1, 10'h011);
    chk("R1 neighbour byte", rdata_o, 32'h0000_0077);
  endtask

  task automatic t_deselect();
    rd(2'b00, 0, 10'h010);
    acc(1, 0, 2'b10, 0, 10'h010, 32'h1111_1111);
    chk("R2 buffer held", rdata_o, 32'h0000_005A);
    chk("R2 mar held", 32'(mar_o), 32'h010);
    acc(1, 1, 2'b00, 1, 10'h0F0, 32'h2222_2222);
    rd(2'b01, 1, 10'h010);
    chk("R2 storage unchanged", rdata_o, 32'h0000_5A77);
  endtask

  task automatic t_doc_example();
    wr(2'b00, 0, 10'h200, 32'h02);
    wr(2'b00, 0, 10'h201, 32'h04);
    wr(2'b00, 0, 10'h202, 32'h06);
    wr(2'b00, 0, 10'h203, 32'h08);
    rd(2'b10, 1, 10'h200);
    chk("R8 R6 word big", rdata_o, 32'h0204_0608);
    rd(2'b10, 0, 10'h200);
    chk("R8 R7 word little", rdata_o, 32'h0806_0402);
    rd(2'b01, 1, 10'h200);
    chk("R8 half big", rdata_o, 32'h0000_0204);
    rd(2'b01, 0, 10'h200);
    chk("R8 half little", rdata_o, 32'h0000_0402);
    rd(2'b11, 1, 10'h200);
    chk("R5 size 11 as word", rdata_o, 32'h0204_0608);
  endtask

  task automatic t_zero_fill();
    rd(2'b00, 1, 10'h202);
    chk("R9 byte zero fill", rdata_o, 32'h0000_0006);
    rd(2'b01, 0, 10'h201);
    chk("R9 half zero fill", rdata_o, 32'h0000_0604);
  endtask

  task automatic t_half_write();
    wr(2'b00, 0, 10'h042, 32'h0000_00EE);
    wr(2'b01, 0, 10'h040, 32'hAAAA_1234);
    rd(2'b00, 0, 10'h040);
    chk("R7 half low byte at Z", rdata_o, 32'h0000_0034);
    rd(2'b00, 0, 10'h042);
    chk("R5 half spans two bytes", rdata_o, 32'h0000_00EE);
    wr(2'b01, 1, 10'h044, 32'h0000_ABCD);
    rd(2'b00, 1, 10'h044);
    chk("R6 half high byte at Z", rdata_o, 32'h0000_00AB);
  endtask

  task automatic t_cross_endian();
    wr(2'b10, 1, 10'h080, 32'h1122_3344);
    rd(2'b10, 0, 10'h080);
    chk("R11 kept across mode change", rdata_o, 32'h4433_2211);
    rd(2'b00, 0, 10'h083);
    chk("R6 last byte least significant", rdata_o, 32'h0000_0044);
  endtask

  task automatic t_wrap();
    wr(2'b10, 1, 10'h3FE, 32'hA1B2_C3D4);
    rd(2'b00, 0, 10'h000);
    chk("R10 wrap byte 0", rdata_o, 32'h0000_00C3);
    rd(2'b00, 0, 10'h001);
    chk("R10 wrap byte 1", rdata_o, 32'h0000_00D4);
    rd(2'b10, 0, 10'h3FE);
    chk("R10 wrapped word little", rdata_o, 32'hD4C3_B2A1);
    rd(2'b01, 1, 10'h3FF);
    chk("R10 half across top", rdata_o, 32'h0000_B2C3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_byte_rw();
    t_deselect();
    t_doc_example();
    t_zero_fill();
    t_half_write();
    t_cross_endian();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule